// File: doc/BRIEF.md
# Programmable Ratio Divider with Code Conversion

This block divides its input clock by an integer ratio N that comes from eight parallel program inputs. A mode input selects how those inputs are read. In binary mode the eight bits are N itself. In decimal mode the low six bits hold a two-digit decimal channel code, and a fixed offset is added to that code to give N. On each clock edge the block registers the decoded ratio and keeps the last ratio that was legal.

A down-counter reloads with N−1 each time it reaches zero. At that moment it emits a tick one input clock wide. A second output, the divided clock, is high for about half of each period. A program code that is not legal raises an inhibit flag, which a transmitter can use to mute itself when a channel selector misbehaves. While the flag is raised the divider keeps running at the last legal ratio.

A ratio change never shortens the period that is already running. The new ratio is loaded only at the next terminal count.

Top module: `prog_ratio_divider`

## Requirements
- R1: With mode input low (binary), the division ratio is the 8-bit value on prog_i. Any value from 3 to 255 is legal.
- R2: With mode input high (decimal), prog_i[3:0] is the units digit and prog_i[5:4] is the tens digit (0–3). The ratio is 90 + 10·tens + units, which spans 90 to 129.
- R3: In decimal mode, prog_i[7:6] has no effect on the ratio or on the inhibit flag.
- R4: inhibit_o is high one clock after the inputs show a binary value below 3, or a decimal units digit above 9. It is low one clock after the inputs show a legal code.
- R5: While the code is not legal, the divider keeps dividing by the last legal ratio.
- R6: tick_o is a pulse one clock wide. It occurs once every N clocks.
- R7: In each period, div_o rises in the same cycle as tick_o. It stays high for ceil(N/2) clocks and low for floor(N/2) clocks.
- R8: A change of ratio takes effect only at the next terminal count. The period in progress completes with the old ratio.
- R9: Synchronous reset clears tick_o, div_o and inhibit_o. The first period after reset is released uses the RESET_RATIO parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| bcd_mode_i | input | 1 | 0 = binary program code, 1 = decimal code plus offset |
| prog_i | input | 8 | Program code |
| tick_o | output | 1 | One-clock pulse at each terminal count |
| div_o | output | 1 | Divided clock, about 50 % duty cycle |
| inhibit_o | output | 1 | High while the program code is not legal |

## Verification
The bench builds the block with RESET_RATIO set to 12 and keeps the defaults MIN_RATIO = 3 and offset 90.

The short reset ratio makes the first period after reset easy to tell apart from the programmed ratios. It also keeps that period short.

With the default minimum and offset, the bench can reach:
- the binary extremes 3 and 255 and the illegal values just below 3;
- both ends of the decimal range (90 and 129);
- units digits above 9;
- codes with the top two bits set in decimal mode.

// File: rtl/prog_ratio_pkg.sv
package prog_ratio_pkg;

    localparam int PROG_W  = 8;
    localparam int RATIO_W = 8;
    localparam int UNITS_W = 4;
    localparam int TENS_W  = 2;
    localparam int TENS_LO = UNITS_W;

    typedef enum logic {
        MODE_BINARY  = 1'b0,
        MODE_DECIMAL = 1'b1
    } prog_mode_e;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic               legal;
    } ratio_cfg_t;

    function automatic logic [RATIO_W-1:0] decimal_ratio(
        input logic [UNITS_W-1:0] units,
        input logic [TENS_W-1:0]  tens,
        input int unsigned        offset
    );
        int unsigned sum;
        sum = offset + 10 * int'(tens) + int'(units);
        return RATIO_W'(sum);
    endfunction

    function automatic logic [RATIO_W-1:0] half_of(input logic [RATIO_W-1:0] n);
        return n >> 1;
    endfunction

endpackage

// File: rtl/prog_decoder.sv
module prog_decoder
    import prog_ratio_pkg::*;
#(
    parameter int MIN_RATIO  = 3,
    parameter int BCD_OFFSET = 90
) (
    input  prog_mode_e        mode,
    input  logic [PROG_W-1:0] prog,
    output ratio_cfg_t        cfg
);

    localparam logic [UNITS_W-1:0] MAX_DIGIT = UNITS_W'(9);
    localparam logic [RATIO_W-1:0] MIN_N     = RATIO_W'(MIN_RATIO);

    logic [UNITS_W-1:0] units;
    logic [TENS_W-1:0]  tens;
    ratio_cfg_t         bin_cfg;
    ratio_cfg_t         dec_cfg;

    assign units = prog[UNITS_W-1:0];
    assign tens  = prog[TENS_LO +: TENS_W];

    always_comb begin
        bin_cfg.ratio = prog[RATIO_W-1:0];
        bin_cfg.legal = (prog[RATIO_W-1:0] >= MIN_N);
    end

    always_comb begin
        dec_cfg.ratio = decimal_ratio(units, tens, BCD_OFFSET);
        dec_cfg.legal = (units <= MAX_DIGIT);
    end

    always_comb begin
        unique case (mode)
            MODE_DECIMAL: cfg = dec_cfg;
            default:      cfg = bin_cfg;
        endcase
    end

endmodule

// File: rtl/ratio_hold.sv
module ratio_hold
    import prog_ratio_pkg::*;
#(
    parameter int RESET_RATIO = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  ratio_cfg_t         cfg_in,
    output ratio_cfg_t         cfg_q,
    output logic [RATIO_W-1:0] held_ratio
);

    localparam logic [RATIO_W-1:0] RST_N = RATIO_W'(RESET_RATIO);

    logic [RATIO_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ratio <= RST_N;
            cfg_q.legal <= 1'b1;
        end else begin
            cfg_q <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= RST_N;
        end else if (cfg_q.legal) begin
            held_q <= cfg_q.ratio;
        end
    end

    assign held_ratio = held_q;

endmodule

// File: rtl/div_counter.sv
module div_counter
    import prog_ratio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] load_ratio,
    output logic               tick_o,
    output logic               div_o
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] half_q;
    logic               tick_q;
    logic               at_terminal;

    assign at_terminal = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= '1;
            tick_q <= 1'b0;
        end else if (at_terminal) begin
            cnt_q  <= load_ratio - RATIO_W'(1);
            half_q <= half_of(load_ratio);
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - RATIO_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;
    assign div_o  = (cnt_q >= half_q);

endmodule

// File: rtl/prog_ratio_divider.sv
module prog_ratio_divider
    import prog_ratio_pkg::*;
#(
    parameter int MIN_RATIO   = 3,
    parameter int BCD_OFFSET  = 90,
    parameter int RESET_RATIO = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bcd_mode_i,
    input  logic [PROG_W-1:0] prog_i,
    output logic              tick_o,
    output logic              div_o,
    output logic              inhibit_o
);

    prog_mode_e         mode;
    ratio_cfg_t         cfg_now;
    ratio_cfg_t         cfg_reg;
    logic [RATIO_W-1:0] held_ratio;

    assign mode = prog_mode_e'(bcd_mode_i);

    prog_decoder #(
        .MIN_RATIO (MIN_RATIO),
        .BCD_OFFSET(BCD_OFFSET)
    ) u_dec (
        .mode(mode),
        .prog(prog_i),
        .cfg (cfg_now)
    );

    ratio_hold #(
        .RESET_RATIO(RESET_RATIO)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_now),
        .cfg_q     (cfg_reg),
        .held_ratio(held_ratio)
    );

    div_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_ratio(held_ratio),
        .tick_o    (tick_o),
        .div_o     (div_o)
    );

    assign inhibit_o = ~cfg_reg.legal;

endmodule

// File: rtl/prog_ratio_checker.sv
module prog_ratio_checker
    import prog_ratio_pkg::*;
#(
    parameter int MIN_RATIO = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               bcd_mode_i,
    input logic [PROG_W-1:0]  prog_i,
    input logic               tick_o,
    input logic               div_o,
    input logic               inhibit_o,
    input logic [RATIO_W-1:0] held_ratio
);

    localparam logic [PROG_W-1:0] MIN_P = PROG_W'(MIN_RATIO);

    AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R6

    AST_DIV_RISES_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(div_o) |-> tick_o); // R7

    AST_LOW_BINARY_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        (!bcd_mode_i && (prog_i < MIN_P)) |=> inhibit_o); // R4

    AST_BAD_DIGIT_INHIBITS: assert property (@(posedge clk) disable iff (rst)
        (bcd_mode_i && (prog_i[3:0] > 4'd9)) |=> inhibit_o); // R4

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
        inhibit_o |=> $stable(held_ratio)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tick_o && !div_o && !inhibit_o)); // R9

endmodule

bind prog_ratio_divider prog_ratio_checker #(
    .MIN_RATIO(MIN_RATIO)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bcd_mode_i(bcd_mode_i),
    .prog_i    (prog_i),
    .tick_o    (tick_o),
    .div_o     (div_o),
    .inhibit_o (inhibit_o),
    .held_ratio(held_ratio)
);

// File: tb/prog_ratio_divider_bench.sv
module prog_ratio_divider_bench;

    localparam int RST_N  = 12;
    localparam int NVEC   = 12;
    localparam int VEC_W  = 18;

    // {mode, prog[7:0], expected ratio[7:0], expected inhibit}
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {1'b0, 8'd3,   8'd3,   1'b0},  // R1 minimum
        {1'b0, 8'd2,   8'd3,   1'b1},  // R4 R5 below minimum
        {1'b0, 8'd255, 8'd255, 1'b0},  // R1 maximum
        {1'b0, 8'd0,   8'd255, 1'b1},  // R4 R5 all zero
        {1'b1, 8'h00,  8'd90,  1'b0},  // R2 lowest decimal
        {1'b1, 8'h39,  8'd129, 1'b0},  // R2 highest decimal
        {1'b1, 8'h1A,  8'd129, 1'b1},  // R4 R5 units 10
        {1'b1, 8'h25,  8'd115, 1'b0},  // R2
        {1'b1, 8'hC7,  8'd97,  1'b0},  // R3 top bits ignored
        {1'b0, 8'd4,   8'd4,   1'b0},  // R1
        {1'b1, 8'h0F,  8'd4,   1'b1},  // R4 R5 units 15
        {1'b0, 8'd100, 8'd100, 1'b0}   // R1
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bcd_mode_i = 1'b0;
    logic [7:0] prog_i = 8'd6;
    logic       tick_o;
    logic       div_o;
    logic       inhibit_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    prog_ratio_divider #(
        .RESET_RATIO(RST_N)
    ) u_prog_ratio_divider (
        .clk       (clk),
        .rst       (rst),
        .bcd_mode_i(bcd_mode_i),
        .prog_i    (prog_i),
        .tick_o    (tick_o),
        .div_o     (div_o),
        .inhibit_o (inhibit_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick_o);
    endtask

    task automatic measure(output int period, output int highs);
        period = 0;
        highs  = 0;
        do begin
            @(negedge clk);
            period++;
            if (div_o) highs++;
        end while (!tick_o);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int p;
        int h;
        int n;
        repeat (3) @(negedge clk);
        check("R9 reset tick", int'(tick_o), 0);
        check("R9 reset div", int'(div_o), 0);
        check("R9 reset inhibit", int'(inhibit_o), 0);
        rst = 1'b0;
        wait_tick();
        measure(p, h);
        check("R9 first period uses reset ratio", p, RST_N);
        measure(p, h);
        check("R1 period after reset", p, 6);

        for (int i = 0; i < NVEC; i++) begin
            bcd_mode_i = VECS[i][17];
            prog_i     = VECS[i][16:9];
            n          = int'(VECS[i][8:1]);
            repeat (2) @(negedge clk);
            check("R4 inhibit flag", int'(inhibit_o), int'(VECS[i][0]));
            repeat (2) @(negedge clk);
            wait_tick();
            measure(p, h);
            check("R1 R2 R3 R5 R6 period", p, n);
            check("R7 high time", h, (n + 1) / 2);
        end

        // R8: change just after a terminal count
        wait_tick();
        bcd_mode_i = 1'b0;
        prog_i     = 8'd5;
        measure(p, h);
        check("R8 running period keeps old ratio", p, 100);
        measure(p, h);
        check("R8 new ratio at next terminal count", p, 5);
        check("R7 odd ratio high time", h, 3);

        // R6: tick is exactly one clock wide
        wait_tick();
        @(negedge clk);
        check("R6 tick one wide", int'(tick_o), 0);

        // R9: reset in mid-run
        prog_i = 8'd1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid-run reset tick", int'(tick_o), 0);
        check("R9 mid-run reset div", int'(div_o), 0);
        check("R9 mid-run reset inhibit", int'(inhibit_o), 0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule